// File: doc/BRIEF.md
# Configuration-driven test frame builder

This block turns short configuration records into complete Ethernet test frames. It streams them out one byte per clock, so that a gigabit link stays fully loaded even with minimum-size frames. Records come from a first-word-fall-through byte FIFO. Each record holds a frame length and an optional set of header values. A small template table holds ready-made frame headers and is filled through a write port before traffic starts. For each frame the builder copies a template header and patches or inserts the supplied fields. It then fills the rest of the frame with a counting payload.

The record parser runs while the current frame is going out, so the next record is usually complete before the inter-frame gap ends. A record is only taken up when a frame boundary is reached. If no complete record is waiting at that point, the builder sends the previous frame again and flags it as a replay, so the link never falls idle once traffic has begun. There is no backpressure on the output. Frame check sequence and MAC functions belong to later stages.

Top module: `fbld_frame_gen`

## Requirements
- R1: A record is read from the FIFO byte by byte, with `cfg_rd` high only while `cfg_empty` is low. The first byte is a presence mask: bit 0 IPv4 address, bit 1 IPv6 address, bit 2 VLAN tag, bit 3 template index; bits 7:4 are ignored. Next comes the 16-bit length, high byte first. The present fields follow in mask-bit order, each high byte first, sized 4, 16, 2 and 2 bytes.
- R2: A frame starts with `tx_sof` and ends with `tx_eof`. `tx_valid` stays high without a hole in between, one byte per cycle. A requested length below 64 gives 64 bytes, and one above 1518 gives 1518 bytes.
- R3: Header bytes come from the template entry chosen by the low bits of the template index (bits 1:0 with 4 entries). Entry 0 is used when no index is supplied. The template is 54 bytes, written at address entry and byte.
- R4: A supplied IPv4 address replaces template bytes 30 to 33, high byte first.
- R5: A supplied IPv6 address replaces template bytes 38 to 53, high byte first.
- R6: A supplied VLAN tag puts bytes 0x81, 0x00, tag high and tag low at frame positions 12 to 15. Template bytes from 12 onward then move 4 positions later, and any address patch follows its template byte.
- R7: After the header (54 bytes, or 58 with a VLAN tag), payload byte i equals i modulo 256.
- R8: If no complete record is pending at a frame boundary, the previous frame is sent again byte for byte, with `tx_replay` high in its `tx_sof` cycle. Before the first record, nothing is sent.
- R9: At least 12 cycles with `tx_valid` low separate each `tx_eof` from the next `tx_sof`.
- R10: A record arriving during a frame, or one still incomplete, never alters or cuts short the frame in progress. It is taken up only at a later frame boundary.
- R11: While reset is high and right after it, all output strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_empty | input | 1 | Record FIFO has no byte |
| cfg_data | input | 8 | Record FIFO head byte (first-word fall-through) |
| cfg_rd | output | 1 | Pop the head byte |
| lut_we | input | 1 | Template write strobe |
| lut_entry | input | 2 | Template entry written |
| lut_byte | input | 6 | Byte position inside the entry |
| lut_wdata | input | 8 | Template byte value |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| tx_replay | output | 1 | Marks the first byte of a repeated frame |

## Verification
The checks assume that the FIFO model keeps its head byte stable until it is popped. They also assume that the template table is loaded only before the first record. Replays rebuild the frame from the held record, so a template change during traffic would make a replay differ from its original. The bench finishes every table write before it pushes any record. It changes FIFO contents only on the falling clock edge. Records reach the FIFO while replays are running, and one record is left unfinished on purpose, to exercise the boundary rule.

// File: rtl/fbld_pkg.sv
package fbld_pkg;
  localparam int M_IP4  = 0;
  localparam int M_IP6  = 1;
  localparam int M_VLAN = 2;
  localparam int M_LIDX = 3;

  typedef struct packed {
    logic [3:0]   mask;
    logic [15:0]  len;
    logic [31:0]  ip4;
    logic [127:0] ip6;
    logic [15:0]  vlan;
    logic [15:0]  lidx;
  } fb_set_t;
endpackage

// File: rtl/fbld_set_parser.sv
module fbld_set_parser
  import fbld_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_empty,
  input  logic [7:0] cfg_data,
  output logic       cfg_rd,
  input  logic       take,
  output logic       pend_valid,
  output fb_set_t    pend_set
);
  logic [4:0] idx, o6, ov, ol, last_idx;

  always_comb begin
    o6       = 5'd3 + (pend_set.mask[M_IP4]  ? 5'd4  : 5'd0);
    ov       = o6   + (pend_set.mask[M_IP6]  ? 5'd16 : 5'd0);
    ol       = ov   + (pend_set.mask[M_VLAN] ? 5'd2  : 5'd0);
    last_idx = ol   + (pend_set.mask[M_LIDX] ? 5'd2  : 5'd0) - 5'd1;
  end

  assign cfg_rd = !pend_valid && !cfg_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      idx        <= '0;
      pend_set   <= '0;
    end else begin
      if (take) pend_valid <= 1'b0;
      if (cfg_rd) begin
        if (idx == 5'd0) begin
          pend_set      <= '0;
          pend_set.mask <= cfg_data[3:0];
        end else if (idx == 5'd1) pend_set.len[15:8] <= cfg_data;
        else if (idx == 5'd2) pend_set.len[7:0] <= cfg_data;
        else if (pend_set.mask[M_IP4] && idx < o6) pend_set.ip4 <= {pend_set.ip4[23:0], cfg_data};
        else if (pend_set.mask[M_IP6] && idx < ov) pend_set.ip6 <= {pend_set.ip6[119:0], cfg_data};
        else if (pend_set.mask[M_VLAN] && idx < ol) pend_set.vlan <= {pend_set.vlan[7:0], cfg_data};
        else pend_set.lidx <= {pend_set.lidx[7:0], cfg_data};
        if (idx != 5'd0 && idx == last_idx) begin
          pend_valid <= 1'b1;
          idx        <= '0;
        end else begin
          idx <= idx + 5'd1;
        end
      end
    end
  end

  AST_PENDING_HELD: assert property (@(posedge clk) disable iff (rst)
    (pend_valid && !take) |=> (pend_valid && $stable(pend_set))); // R10
endmodule

// File: rtl/fbld_tpl_lut.sv
module fbld_tpl_lut #(
  parameter int ENTRIES = 4,
  parameter int HDR_LEN = 54,
  localparam int DEPTH  = ENTRIES * HDR_LEN,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fbld_byte_mux.sv
module fbld_byte_mux
  import fbld_pkg::*;
#(
  parameter int HDR_LEN  = 54,
  parameter int IP4_OFS  = 30,
  parameter int IP6_OFS  = 38,
  parameter int VLAN_OFS = 12,
  parameter int LEN_W    = 11
) (
  input  logic [LEN_W-1:0] pos,
  input  fb_set_t          set,
  input  logic [7:0]       tpl,
  output logic [7:0]       dout
);
  localparam logic [LEN_W-1:0] L_HDR = LEN_W'(HDR_LEN);
  localparam logic [LEN_W-1:0] L_VO  = LEN_W'(VLAN_OFS);
  localparam logic [LEN_W-1:0] L_VE  = LEN_W'(VLAN_OFS + 4);
  localparam logic [LEN_W-1:0] L_I4  = LEN_W'(IP4_OFS);
  localparam logic [LEN_W-1:0] L_I4E = LEN_W'(IP4_OFS + 4);
  localparam logic [LEN_W-1:0] L_I6  = LEN_W'(IP6_OFS);
  localparam logic [LEN_W-1:0] L_I6E = LEN_W'(IP6_OFS + 16);

  logic [LEN_W-1:0] hl, q, k4, k6, kv;
  logic unused_fields;
  assign unused_fields = ^{set.len, set.lidx};

  always_comb begin
    hl   = L_HDR + (set.mask[M_VLAN] ? LEN_W'(4) : LEN_W'(0));
    q    = (set.mask[M_VLAN] && pos >= L_VE) ? pos - LEN_W'(4) : pos;
    k4   = q - L_I4;
    k6   = q - L_I6;
    kv   = pos - L_VO;
    dout = tpl;
    if (pos >= hl) begin
      dout = 8'(pos - hl);
    end else if (set.mask[M_VLAN] && pos >= L_VO && pos < L_VE) begin
      case (kv[1:0])
        2'd0:    dout = 8'h81;
        2'd1:    dout = 8'h00;
        2'd2:    dout = set.vlan[15:8];
        default: dout = set.vlan[7:0];
      endcase
    end else if (set.mask[M_IP4] && q >= L_I4 && q < L_I4E) begin
      dout = set.ip4[(3 - int'(k4[1:0])) * 8 +: 8];
    end else if (set.mask[M_IP6] && q >= L_I6 && q < L_I6E) begin
      dout = set.ip6[(15 - int'(k6[3:0])) * 8 +: 8];
    end
  end
endmodule

// File: rtl/fbld_frame_gen.sv
module fbld_frame_gen
  import fbld_pkg::*;
#(
  parameter int LUT_ENTRIES = 4,
  parameter int HDR_LEN     = 54,
  parameter int IP4_OFS     = 30,
  parameter int IP6_OFS     = 38,
  parameter int VLAN_OFS    = 12,
  parameter int MIN_LEN     = 64,
  parameter int MAX_LEN     = 1518,
  parameter int IFG         = 12,
  localparam int IDX_W      = $clog2(LUT_ENTRIES),
  localparam int HB_W       = $clog2(HDR_LEN),
  localparam int AW         = $clog2(LUT_ENTRIES * HDR_LEN),
  localparam int LEN_W      = $clog2(MAX_LEN + 1),
  localparam int GAP_W      = $clog2(IFG + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_empty,
  input  logic [7:0]       cfg_data,
  output logic             cfg_rd,
  input  logic             lut_we,
  input  logic [IDX_W-1:0] lut_entry,
  input  logic [HB_W-1:0]  lut_byte,
  input  logic [7:0]       lut_wdata,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_sof,
  output logic             tx_eof,
  output logic             tx_replay
);
  logic             pend_valid, take;
  fb_set_t          pend_set, cur;
  logic             busy, rep, have_frame;
  logic [LEN_W-1:0] pos, flen, q0;
  logic [GAP_W-1:0] gap;
  logic [AW-1:0]    waddr, raddr;
  logic [7:0]       tpl_byte, mux_byte;
  logic             s1_act, s1_last, s1_rep;
  logic [LEN_W-1:0] s1_pos;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [15:0] l);
    if (l < 16'(MIN_LEN)) return LEN_W'(MIN_LEN);
    else if (l > 16'(MAX_LEN)) return LEN_W'(MAX_LEN);
    else return LEN_W'(l);
  endfunction

  fbld_set_parser u_parser (
    .clk(clk), .rst(rst), .cfg_empty(cfg_empty), .cfg_data(cfg_data), .cfg_rd(cfg_rd),
    .take(take), .pend_valid(pend_valid), .pend_set(pend_set)
  );

  assign take = !busy && gap == '0 && pend_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; rep <= 1'b0; have_frame <= 1'b0;
      pos <= '0; flen <= '0; gap <= '0; cur <= '0;
    end else if (busy) begin
      if (pos == flen - LEN_W'(1)) begin
        busy       <= 1'b0;
        gap        <= GAP_W'(IFG - 1);
        have_frame <= 1'b1;
      end
      pos <= pos + LEN_W'(1);
    end else if (gap != '0) begin
      gap <= gap - GAP_W'(1);
    end else if (take) begin
      busy <= 1'b1; pos <= '0; rep <= 1'b0;
      cur  <= pend_set;
      flen <= clamp_len(pend_set.len);
    end else if (have_frame) begin
      busy <= 1'b1; pos <= '0; rep <= 1'b1;
    end
  end

  // template address for the byte at stage 0
  always_comb begin
    q0 = (cur.mask[M_VLAN] && pos >= LEN_W'(VLAN_OFS + 4)) ? pos - LEN_W'(4) : pos;
    if (q0 >= LEN_W'(HDR_LEN)) q0 = '0;
  end
  assign raddr = AW'(cur.lidx[IDX_W-1:0]) * AW'(HDR_LEN) + AW'(q0);
  assign waddr = AW'(lut_entry) * AW'(HDR_LEN) + AW'(lut_byte);

  fbld_tpl_lut #(.ENTRIES(LUT_ENTRIES), .HDR_LEN(HDR_LEN)) u_lut (
    .clk(clk), .we(lut_we), .waddr(waddr), .wdata(lut_wdata), .raddr(raddr), .rdata(tpl_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_act <= 1'b0; s1_last <= 1'b0; s1_rep <= 1'b0; s1_pos <= '0;
    end else begin
      s1_act  <= busy;
      s1_last <= busy && pos == flen - LEN_W'(1);
      s1_rep  <= rep;
      s1_pos  <= pos;
    end
  end

  fbld_byte_mux #(.HDR_LEN(HDR_LEN), .IP4_OFS(IP4_OFS), .IP6_OFS(IP6_OFS),
                  .VLAN_OFS(VLAN_OFS), .LEN_W(LEN_W)) u_mux (
    .pos(s1_pos), .set(cur), .tpl(tpl_byte), .dout(mux_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0; tx_data <= '0; tx_sof <= 1'b0; tx_eof <= 1'b0; tx_replay <= 1'b0;
    end else begin
      tx_valid  <= s1_act;
      tx_data   <= s1_act ? mux_byte : 8'h00;
      tx_sof    <= s1_act && s1_pos == '0;
      tx_eof    <= s1_act && s1_last;
      tx_replay <= s1_act && s1_pos == '0 && s1_rep;
    end
  end

  // observation state for the output checks
  localparam int IW = $clog2(IFG + 1);
  logic [LEN_W:0] ob_cnt;
  logic [IW-1:0]  idle_cnt;
  logic           seen_eof;
  always_ff @(posedge clk) begin
    if (rst) begin
      ob_cnt <= '0; idle_cnt <= '0; seen_eof <= 1'b0;
    end else begin
      if (tx_valid) ob_cnt <= tx_eof ? '0 : ob_cnt + 1'b1;
      if (tx_valid) idle_cnt <= '0;
      else if (idle_cnt != IW'(IFG)) idle_cnt <= idle_cnt + 1'b1;
      if (tx_eof) seen_eof <= 1'b1;
    end
  end

  AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    tx_eof |-> (ob_cnt + 1'b1 >= (LEN_W+1)'(MIN_LEN) && ob_cnt + 1'b1 <= (LEN_W+1)'(MAX_LEN))); // R2
  AST_SOF_OPENS: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> tx_sof); // R2
  AST_EOF_CLOSES: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_valid) |-> $past(tx_eof)); // R2
  AST_GAP_KEPT: assert property (@(posedge clk) disable iff (rst)
    (tx_sof && seen_eof) |-> idle_cnt >= IW'(IFG)); // R9
  AST_REPLAY_AT_SOF: assert property (@(posedge clk) disable iff (rst)
    tx_replay |-> tx_sof); // R8
endmodule

// File: tb/fbld_frame_gen_tb.sv
`timescale 1ns/1ps
module fbld_frame_gen_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_empty, cfg_rd, lut_we = 1'b0;
  logic [7:0] cfg_data, lut_wdata = '0, tx_data;
  logic [1:0] lut_entry = '0;
  logic [5:0] lut_byte = '0;
  logic tx_valid, tx_sof, tx_eof, tx_replay;

  always #2.5 clk = ~clk;

  fbld_frame_gen u_dut (
    .clk(clk), .rst(rst), .cfg_empty(cfg_empty), .cfg_data(cfg_data), .cfg_rd(cfg_rd),
    .lut_we(lut_we), .lut_entry(lut_entry), .lut_byte(lut_byte), .lut_wdata(lut_wdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_replay(tx_replay)
  );

  // FIFO model, first-word fall-through
  logic [7:0] fifo [512];
  int head = 0, tail = 0;
  assign cfg_empty = (head == tail);
  assign cfg_data  = fifo[head % 512];
  always @(posedge clk) if (cfg_rd) head <= head + 1;

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // output monitor
  logic [7:0] cap [2][2048];
  int fr_len [2];
  bit fr_rep [2];
  int wsel = 0, lastb = 0, cur_n = 0, frame_cnt = 0, holes = 0, rd_bad = 0;
  int gap_run = 0, min_gap = 1000000;
  bit cur_rep = 0, in_frame = 0, seen_eof = 0;
  always @(negedge clk) if (!rst) begin
    if (cfg_rd && cfg_empty) rd_bad++;
    if (tx_valid) begin
      if (tx_sof) begin
        cur_n = 0; cur_rep = tx_replay; in_frame = 1;
        if (seen_eof && gap_run < min_gap) min_gap = gap_run;
      end
      if (cur_n < 2048) cap[wsel][cur_n] = tx_data;
      cur_n++; gap_run = 0;
      if (tx_eof) begin
        fr_len[wsel] = cur_n; fr_rep[wsel] = cur_rep; lastb = wsel; wsel ^= 1;
        in_frame = 0; seen_eof = 1; frame_cnt++;
      end
    end else begin
      if (in_frame) holes++;
      gap_run++;
    end
  end

  // model of the expected frame
  logic [7:0] tpl [4][54];
  int e_mask = 0, e_len = 0;
  logic [31:0] e_ip4 = '0;
  logic [127:0] e_ip6 = '0;
  logic [15:0] e_vlan = '0, e_lidx = '0;

  function automatic logic [7:0] exp_b(input int p);
    int hl, q; logic [7:0] b;
    hl = 54 + (e_mask[2] ? 4 : 0);
    if (p >= hl) return 8'((p - hl) % 256);
    if (e_mask[2] && p >= 12 && p < 16) begin
      case (p)
        12: return 8'h81;
        13: return 8'h00;
        14: return e_vlan[15:8];
        default: return e_vlan[7:0];
      endcase
    end
    q = (e_mask[2] && p >= 16) ? p - 4 : p;
    b = tpl[e_mask[3] ? int'(e_lidx[1:0]) : 0][q];
    if (e_mask[0] && q >= 30 && q < 34) b = 8'(e_ip4 >> (8 * (33 - q)));
    if (e_mask[1] && q >= 38 && q < 54) b = 8'(e_ip6 >> (8 * (53 - q)));
    return b;
  endfunction

  function automatic int clamp(input int l);
    return (l < 64) ? 64 : (l > 1518) ? 1518 : l;
  endfunction

  logic [7:0] sb [40];
  int sn;
  task automatic build_set(input int m, input int len, input logic [31:0] i4,
                           input logic [127:0] i6, input logic [15:0] vl, input logic [15:0] li);
    sn = 0;
    sb[sn++] = 8'(m); sb[sn++] = 8'(len >> 8); sb[sn++] = 8'(len);
    if (m[0]) for (int k = 3; k >= 0; k--) sb[sn++] = i4[k*8 +: 8];
    if (m[1]) for (int k = 15; k >= 0; k--) sb[sn++] = i6[k*8 +: 8];
    if (m[2]) begin sb[sn++] = vl[15:8]; sb[sn++] = vl[7:0]; end
    if (m[3]) begin sb[sn++] = li[15:8]; sb[sn++] = li[7:0]; end
  endtask

  task automatic push_range(input int from, input int upto);
    @(negedge clk);
    for (int k = from; k < upto; k++) begin fifo[tail % 512] = sb[k]; tail++; end
  endtask

  task automatic set_expect(input int m, input int len, input logic [31:0] i4,
                            input logic [127:0] i6, input logic [15:0] vl, input logic [15:0] li);
    e_mask = m & 15; e_len = clamp(len); e_ip4 = i4; e_ip6 = i6; e_vlan = vl; e_lidx = li;
  endtask

  task automatic send_set(input int m, input int len, input logic [31:0] i4,
                          input logic [127:0] i6, input logic [15:0] vl, input logic [15:0] li);
    build_set(m, len, i4, i6, vl, li);
    push_range(0, sn);
    set_expect(m, len, i4, i6, vl, li);
  endtask

  task automatic wait_new();
    do @(frame_cnt); while (fr_rep[lastb]);
  endtask

  task automatic cmp_frame(input string req, input int b);
    int bad = 0, first = -1;
    chk(fr_len[b] == e_len, req, "frame length", fr_len[b], e_len);
    for (int p = 0; p < e_len && p < fr_len[b]; p++)
      if (cap[b][p] !== exp_b(p)) begin bad++; if (first < 0) first = p; end
    chk(bad == 0, req, $sformatf("byte at %0d", first),
        first < 0 ? 0 : cap[b][first], first < 0 ? 0 : exp_b(first));
  endtask

  // scenarios
  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!tx_valid && !tx_sof && !tx_eof && !tx_replay && !cfg_rd, "R11", "strobes in reset",
        {tx_valid, tx_sof, tx_eof, tx_replay}, 0);
    @(negedge clk) rst = 1'b0;
    for (int e = 0; e < 4; e++)
      for (int b = 0; b < 54; b++) begin
        tpl[e][b] = 8'((e * 61 + b * 7 + 3) % 256);
        lut_we = 1'b1; lut_entry = 2'(e); lut_byte = 6'(b); lut_wdata = tpl[e][b];
        @(negedge clk);
      end
    lut_we = 1'b0;
    repeat (20) @(negedge clk);
    chk(frame_cnt == 0 && !tx_valid, "R8", "output before first record", frame_cnt, 0);
  endtask

  task automatic t_plain();
    send_set(8'hF0, 100, '0, '0, '0, '0); // upper mask bits ignored (R1)
    wait_new();
    cmp_frame("R1 R3 R7 plain", lastb);
  endtask

  task automatic t_replay();
    @(frame_cnt);
    chk(fr_rep[lastb] == 1'b1, "R8", "replay flag", fr_rep[lastb], 1);
    cmp_frame("R8 replay", lastb);
  endtask

  task automatic t_ipv4();
    send_set(1, 64, 32'hC0A8_0117, '0, '0, '0);
    wait_new();
    cmp_frame("R4 ipv4", lastb);
  endtask

  task automatic t_ipv6_lut();
    send_set(8'h0A, 300, '0, 128'h2001_0DB8_0000_1111_2222_3333_4444_5566, '0, 16'h0106);
    wait_new();
    cmp_frame("R3 R5 ipv6 index", lastb);
  endtask

  task automatic t_vlan_all();
    send_set(15, 2000, 32'h0A00_00FE, 128'hFEDC_BA98_7654_3210_0123_4567_89AB_CDEF,
             16'hA07B, 16'h0001);
    wait_new();
    chk(fr_rep[lastb ^ 1] && fr_len[lastb ^ 1] == 300, "R10", "frame before new record",
        fr_len[lastb ^ 1], 300);
    cmp_frame("R6 R2 vlan clamp high", lastb);
  endtask

  task automatic t_short();
    send_set(4, 5, '0, '0, 16'h0003, '0);
    wait_new();
    cmp_frame("R2 R6 clamp low", lastb);
  endtask

  task automatic t_partial();
    build_set(0, 77, '0, '0, '0, '0);
    push_range(0, 2);
    repeat (2) begin
      @(frame_cnt);
      chk(fr_rep[lastb] && fr_len[lastb] == 64, "R10", "replay during partial record",
          fr_len[lastb], 64);
    end
    push_range(2, 3);
    set_expect(0, 77, '0, '0, '0, '0);
    wait_new();
    cmp_frame("R1 R10 completed record", lastb);
  endtask

  int cyc = 0;
  bit done = 0;
  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
      summary();
    end
  end

  initial begin
    t_reset();
    t_plain();
    t_replay();
    t_ipv4();
    t_ipv6_lut();
    t_vlan_all();
    t_short();
    t_partial();
    repeat (200) @(negedge clk);
    chk(min_gap >= 12, "R9", "smallest gap", min_gap, 12);
    chk(holes == 0, "R2", "holes inside frames", holes, 0);
    chk(rd_bad == 0, "R1", "reads while empty", rd_bad, 0);
    done = 1;
    summary();
  end
endmodule